// File: doc/BRIEF.md
# Extended Target Address Generator

This block is the operand-addressing stage of a small accumulator-style processor that has a basic instruction model and an extended one. It receives one decoded 3-byte or 4-byte instruction together with the address of the next instruction, the base register and the index register. From these it forms a 20-bit target address and then decides how that address is used. It either returns the address itself as an immediate operand, returns it as the operand's address, or fetches a 3-byte pointer word from memory and returns the address held in that word.

The block uses two independent groups of flags. The `n`/`i` pair selects how the address is used. The `x`/`b`/`p`/`e` group selects how it is formed. When both `n` and `i` are clear, the instruction is treated as a basic-model instruction: `b`, `p` and `e` become the top of a 15-bit absolute address, and only `x` keeps its meaning.

A result is reported with a one-cycle `valid` pulse. Two side outputs go with it: a flag that marks the result as an immediate value, and an error flag for illegal flag combinations. An indirect access reads one byte per cycle through a simple read port with combinational return data. The whole access takes three cycles longer than the other modes.

Top module: `tgt_addr_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `valid`, `err` and `mem_rd` are low until a `start` is accepted.
- R2: Field layout: `instr[25]`=n, `[24]`=i, `[23]`=x, `[22]`=b, `[21]`=p, `[20]`=e, `[19:8]`=12-bit displacement, `[19:0]`=20-bit address field. With i=1 and n=0 the result is the target address, `opnd_is_imm`=1, no memory read occurs, and `valid` rises on the clock edge that accepts `start`.
- R3: With n=i=1 the result is the target address, `opnd_is_imm`=0, and there is no memory read. Timing is the same as R2.
- R4: With n=1 and i=0 the block reads bytes at TA, TA+1 and TA+2 on three consecutive cycles. The first byte is the most significant. The low 20 bits of the 24-bit word are returned, and `valid` comes three edges later than in R2.
- R5: With n=i=0 the target address is `instr[22:8]`, zero-extended, plus X when x=1. It is used as a simple address, and no combination of the flags is an error.
- R6: With e=1 (not legacy) the target address is `instr[19:0]`.
- R7: With b=1 the target address is B plus the unsigned displacement (0..4095).
- R8: With p=1 the target address is `pc_next` plus the displacement read as signed 12-bit.
- R9: With b=p=e=0 (not legacy) the target address is the displacement, zero-extended.
- R10: With x=1 the index register is added to the target address. All address sums wrap modulo 2^20.
- R11: Outside legacy format, these combinations are illegal: x=1 with immediate or indirect use, b=p=1, and b or p together with e=1. An illegal instruction gives `valid`=1, `err`=1, `opnd_is_imm`=0 and `opnd_out`=0, with no memory read.
- R12: A `start` that arrives while an indirect read is in progress is ignored. The pending result is unchanged, and no extra `valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Present an instruction for addressing |
| instr | input | 26 | Mode flags and address field |
| pc_next | input | 20 | Address of the following instruction |
| base_reg | input | 20 | Base register B |
| idx_reg | input | 20 | Index register X |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| valid | output | 1 | One-cycle result strobe |
| err | output | 1 | Illegal combination, qualified by `valid` |
| opnd_is_imm | output | 1 | Result is an immediate value |
| opnd_out | output | 20 | Operand value or operand address |

## Verification
The hardest case to reach is a new `start` arriving in the middle of an indirect pointer fetch. A bench that waits for each result before issuing the next instruction never produces it. The bench therefore issues a deliberate second instruction, with different flags and fields, two cycles into an indirect access. It then checks that the pointer result, the read count and the single strobe are all unchanged. The address-wrap corners are reached by a full sweep of all 64 flag combinations over register sets chosen to straddle the 2^20 boundary: a base near the top, an all-ones index, and negative and extreme PC-relative displacements.

// File: rtl/tgt_addr_unit.sv
module tgt_addr_unit #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [25:0]   instr,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] idx_reg,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          valid,
  output logic          err,
  output logic          opnd_is_imm,
  output logic [AW-1:0] opnd_out
);

  localparam int DW = 12;
  localparam int LW = 15;
  localparam int HW = AW - 8;

  logic n_f, i_f, x_f, b_f, p_f, e_f;
  assign {n_f, i_f, x_f, b_f, p_f, e_f} = instr[25:20];

  logic [DW-1:0] disp;
  assign disp = instr[19:8];

  logic legacy, indirect, bad;
  assign legacy   = ~n_f & ~i_f;
  assign indirect = n_f & ~i_f;
  assign bad      = ~legacy & ((b_f & p_f) | ((b_f | p_f) & e_f) | (x_f & (n_f ^ i_f)));

  logic [AW-1:0] ta_raw, ta;
  always_comb begin
    if (legacy)      ta_raw = {{(AW-LW){1'b0}}, instr[22:8]};
    else if (e_f)    ta_raw = instr[AW-1:0];
    else if (b_f)    ta_raw = base_reg + {{(AW-DW){1'b0}}, disp};
    else if (p_f)    ta_raw = pc_next + {{(AW-DW){disp[DW-1]}}, disp};
    else             ta_raw = {{(AW-DW){1'b0}}, disp};
  end
  assign ta = ta_raw + (x_f ? idx_reg : '0);

  logic          busy;
  logic [1:0]    phase;
  logic [AW-1:0] ptr;
  logic [HW-1:0] acc;

  assign mem_rd   = busy;
  assign mem_addr = ptr + AW'(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      phase       <= '0;
      ptr         <= '0;
      acc         <= '0;
      valid       <= 1'b0;
      err         <= 1'b0;
      opnd_is_imm <= 1'b0;
      opnd_out    <= '0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (bad) begin
            valid       <= 1'b1;
            err         <= 1'b1;
            opnd_is_imm <= 1'b0;
            opnd_out    <= '0;
          end else if (indirect) begin
            busy  <= 1'b1;
            phase <= '0;
            ptr   <= ta;
          end else begin
            valid       <= 1'b1;
            opnd_is_imm <= i_f & ~n_f;
            opnd_out    <= ta;
          end
        end
      end else begin
        case (phase)
          2'd0: begin
            acc[HW-1:8] <= mem_rdata[HW-9:0];
            phase       <= 2'd1;
          end
          2'd1: begin
            acc[7:0] <= mem_rdata;
            phase    <= 2'd2;
          end
          default: begin
            opnd_out    <= {acc, mem_rdata};
            opnd_is_imm <= 1'b0;
            valid       <= 1'b1;
            busy        <= 1'b0;
            phase       <= '0;
          end
        endcase
      end
    end
  end

  // R11
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (valid && !opnd_is_imm && opnd_out == '0));

  // R4
  byte_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R4
  fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |-> (valid && !err));

  // R12
  no_strobe_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !valid);

  // R2
  imm_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && opnd_is_imm) |-> !err);

endmodule

// File: tb/test_tgt_addr_unit.sv
`timescale 1ns/1ps
module test_tgt_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [25:0] instr = '0;
  logic [19:0] pc_next = '0, base_reg = '0, idx_reg = '0;
  logic        mem_rd;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        valid, err, opnd_is_imm;
  logic [19:0] opnd_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tgt_addr_unit i_tgt_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .pc_next(pc_next), .base_reg(base_reg), .idx_reg(idx_reg),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .valid(valid), .err(err), .opnd_is_imm(opnd_is_imm), .opnd_out(opnd_out)
  );

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return 8'((int'(a[7:0]) * 37 + int'(a[15:8]) + 11) % 256);
  endfunction

  assign mem_rdata = mbyte(mem_addr);

  function automatic void model(input logic [25:0] ins, input logic [19:0] pcv, bv, xv,
                                output logic eerr, output logic eimm,
                                output logic [19:0] eval, output logic eind);
    logic n, i, x, b, p, e, leg;
    logic [19:0] t;
    logic [7:0] b0, b1, b2;
    int sd;
    n = ins[25]; i = ins[24]; x = ins[23]; b = ins[22]; p = ins[21]; e = ins[20];
    leg = !n && !i;
    eerr = !leg && ((b && p) || ((b || p) && e) || (x && (n != i)));
    eimm = 1'b0; eind = 1'b0; eval = '0;
    if (eerr) return;
    if (leg) t = 20'(int'(ins[22:8]));                // R5
    else if (e) t = ins[19:0];                         // R6
    else if (b) t = 20'(int'(bv) + int'(ins[19:8]));   // R7
    else if (p) begin                                  // R8
      sd = int'(ins[19:8]);
      if (sd >= 2048) sd = sd - 4096;
      t = 20'(int'(pcv) + sd);
    end else t = 20'(int'(ins[19:8]));                 // R9
    if (x) t = 20'(int'(t) + int'(xv));                // R10
    if (i && !n) begin eimm = 1'b1; eval = t; end
    else if (n && !i) begin
      eind = 1'b1;
      b0 = mbyte(t); b1 = mbyte(20'(t + 20'd1)); b2 = mbyte(20'(t + 20'd2));
      eval = {b0[3:0], b1, b2};
    end else eval = t;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [25:0] ins, input logic eerr);
    if (eerr) return "R11";
    if (!ins[25] && !ins[24]) return "R5";
    if (!ins[25] && ins[24]) return "R2";
    if (ins[25] && !ins[24]) return "R4";
    return "R3";
  endfunction

  task automatic run(input logic [25:0] ins, input logic [19:0] pcv, bv, xv, input bit intrude);
    logic eerr, eimm, eind;
    logic [19:0] eval;
    int lat, rds, extra;
    string tg;
    model(ins, pcv, bv, xv, eerr, eimm, eval, eind);
    tg = tag_of(ins, eerr);
    @(negedge clk);
    start = 1'b1; instr = ins; pc_next = pcv; base_reg = bv; idx_reg = xv;
    @(negedge clk);
    start = 1'b0;
    lat = 1; rds = 0;
    while (!valid && lat < 12) begin
      if (mem_rd) rds++;
      if (intrude && lat == 2) begin
        start = 1'b1; instr = 26'h2D_FFFF; base_reg = 20'h11111;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tg, " result"}, valid && err == eerr && opnd_is_imm == eimm && opnd_out == eval,
          {9'd0, valid, err, opnd_is_imm, opnd_out}, {9'd0, 1'b1, eerr, eimm, eval});
    check({tg, " latency/reads"}, lat == (eind ? 4 : 1) && rds == (eind ? 3 : 0),
          32'(lat * 16 + rds), 32'((eind ? 4 : 1) * 16 + (eind ? 3 : 0)));
    if (intrude) begin
      extra = 0;
      repeat (4) begin @(negedge clk); if (valid || mem_rd) extra++; end
      check("R12 no extra strobe", extra == 0, 32'(extra), 32'd0);
    end
  endtask

  initial begin
    logic [19:0] pcv, bv, xv, fld;
    repeat (3) @(negedge clk);
    check("R1 reset", !valid && !err && !mem_rd, {29'd0, valid, err, mem_rd}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", !valid && !err && !mem_rd, {29'd0, valid, err, mem_rd}, 32'd0);
    for (int pat = 0; pat < 4; pat++) begin
      case (pat)
        0: begin pcv = 20'h00100; bv = 20'h00200; xv = 20'h00003; fld = 20'h12345; end
        1: begin pcv = 20'h00010; bv = 20'hFFF80; xv = 20'hFFFFF; fld = 20'hFFF00; end
        2: begin pcv = 20'hFFFFE; bv = 20'h00000; xv = 20'h80000; fld = 20'h80012; end
        default: begin pcv = 20'h54321; bv = 20'h0ABCD; xv = 20'h00042; fld = 20'h7FF9A; end
      endcase
      for (int f = 0; f < 64; f++) run({6'(f), fld}, pcv, bv, xv, 1'b0);
    end
    // R12: second instruction during an indirect fetch
    run({6'b100010, 20'h00456}, 20'h00100, 20'h00300, 20'h0, 1'b1);
    run({6'b100000, 20'hABCDE}, 20'h0, 20'h0, 20'h0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule